// File: doc/BRIEF.md
# Stage Start-Time Flag Search

This block picks the start time of one scheduled operation from a row of per-time-slot choice bits. Each time slot (a "state") carries one choice bit that says whether starting the operation at that slot was the cheaper option found by the backward cost pass. A separate one-hot vector marks the earliest slot the operation may use, which is one past the completion slot of the operation before it. The block scans upward from that earliest slot and takes the first slot whose choice bit is set.

The scan is a chain of small cells, one per slot, each passing a "still searching" bit to the slot above. The cells are grouped. A group holding no earliest-slot mark and no set choice bit cannot change the searching bit, so a skip path carries the bit straight past the group, as in a carry-skip adder. The result is captured when `start` is pulsed and appears on the registered outputs one clock later: a one-hot start vector, its binary index, a not-found flag and the row of searching bits.

Top module: `sweep_flag_search`

## Requirements
- R1: While `rst` is high, and after it is released until the first `start`, `time_vec`, `time_idx`, `search_vec`, `not_found` and `valid` are all 0.
- R2: When `start` is 1 at a rising clock edge, `valid` is 1 during the following cycle and all result outputs reflect the inputs sampled at that edge; at an edge where `start` is 0, `valid` goes to 0 and the result outputs keep their values.
- R3: With the earliest slot at index b (bit b of `begin_vec` set, bit 0 is slot 0), `time_vec` has exactly one bit set, at the lowest index i >= b with `state_flags[i]` = 1, when such an index exists.
- R4: The earliest slot itself is searching: if `state_flags[b]` = 1 then `time_vec` has only bit b set.
- R5: Choice bits at indices below b have no effect on any output.
- R6: Choice bits above the selected slot have no effect on any output.
- R7: Bit i of `search_vec` is 1 exactly when b <= i and no slot j with b <= j <= i has its choice bit set; it is 0 below b and from the selected slot upward.
- R8: When no choice bit is set at index b or above, `time_vec` is 0, `time_idx` is 0 and `not_found` is 1; otherwise `not_found` is 0.
- R9: `time_idx` is the binary position of the set bit in `time_vec` (slot 0 encodes as 0, slot 15 as 15).
- R10: A group of four slots with no earliest-slot mark and no set choice bit passes the searching bit unchanged to the next group, so a search starting in a low group reaches a choice bit several groups higher.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Capture a search result at this edge |
| begin_vec | input | 16 | One-hot mark of the earliest allowed slot |
| state_flags | input | 16 | Per-slot choice bits from the cost pass |
| valid | output | 1 | Result captured at the previous edge |
| time_vec | output | 16 | One-hot selected start slot |
| time_idx | output | 4 | Binary index of the selected slot |
| not_found | output | 1 | No selectable slot at or above the earliest slot |
| search_vec | output | 16 | Searching bit leaving each slot |

## Verification
The assertions take `begin_vec` to be one-hot whenever `start` is high; with no mark or several marks the selected slot is not defined by the requirements. The stimulus draws the earliest slot as a random index and sets exactly that bit, while the choice bits are random with varied density, including all-zero rows, rows set only below the earliest slot and rows set everywhere. Directed cases put the earliest slot at both ends and at group edges and leave whole groups empty between it and the first set bit.

// File: rtl/sweep_pkg.sv
package sweep_pkg;
  localparam int unsigned SW_STATES = 16;
  localparam int unsigned SW_GROUP  = 4;
endpackage

// File: rtl/sweep_cell.sv
module sweep_cell (
  input  logic begin_f,
  input  logic state_f,
  input  logic search_in,
  output logic search_out,
  output logic time_f
);
  logic active;
  always_comb begin
    active     = search_in | begin_f;
    time_f     = active & state_f;
    search_out = active & ~state_f;
  end
endmodule

// File: rtl/sweep_group.sv
module sweep_group #(
  parameter int unsigned GW = 4
) (
  input  logic          carry_in,
  input  logic [GW-1:0] begin_f,
  input  logic [GW-1:0] state_f,
  output logic [GW-1:0] time_f,
  output logic [GW-1:0] search_f,
  output logic          ripple_out,
  output logic          skip,
  output logic          carry_out
);
  logic [GW:0] chain;

  assign chain[0] = carry_in;

  for (genvar c = 0; c < GW; c++) begin : g_cell
    sweep_cell cell_i (
      .begin_f   (begin_f[c]),
      .state_f   (state_f[c]),
      .search_in (chain[c]),
      .search_out(chain[c+1]),
      .time_f    (time_f[c])
    );
    assign search_f[c] = chain[c+1];
  end

  assign ripple_out = chain[GW];
  assign skip       = ~(|begin_f) & ~(|state_f);
  assign carry_out  = skip ? carry_in : ripple_out;
endmodule

// File: rtl/sweep_encoder.sv
module sweep_encoder #(
  parameter int unsigned N  = 16,
  localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  onehot,
  output logic [IW-1:0] index,
  output logic          none
);
  always_comb begin
    index = '0;
    for (int unsigned k = 0; k < N; k++) begin
      if (onehot[k]) index = index | IW'(k);
    end
    none = ~(|onehot);
  end
endmodule

// File: rtl/sweep_flag_search.sv
module sweep_flag_search
  import sweep_pkg::*;
#(
  parameter int unsigned N_STATES = SW_STATES,
  parameter int unsigned GROUP_W  = SW_GROUP,
  localparam int unsigned N_GRP   = N_STATES / GROUP_W,
  localparam int unsigned IDX_W   = (N_STATES > 1) ? $clog2(N_STATES) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic [N_STATES-1:0] begin_vec,
  input  logic [N_STATES-1:0] state_flags,
  output logic                valid,
  output logic [N_STATES-1:0] time_vec,
  output logic [IDX_W-1:0]    time_idx,
  output logic                not_found,
  output logic [N_STATES-1:0] search_vec
);
  logic [N_GRP:0]        carry;
  logic [N_GRP-1:0]      grp_skip;
  logic [N_GRP-1:0]      grp_ripple;
  logic [N_STATES-1:0]   time_c;
  logic [N_STATES-1:0]   search_c;
  logic [IDX_W-1:0]      idx_c;
  logic                  none_c;

  assign carry[0] = 1'b0;

  for (genvar g = 0; g < N_GRP; g++) begin : g_grp
    sweep_group #(.GW(GROUP_W)) grp_i (
      .carry_in  (carry[g]),
      .begin_f   (begin_vec[g*GROUP_W +: GROUP_W]),
      .state_f   (state_flags[g*GROUP_W +: GROUP_W]),
      .time_f    (time_c[g*GROUP_W +: GROUP_W]),
      .search_f  (search_c[g*GROUP_W +: GROUP_W]),
      .ripple_out(grp_ripple[g]),
      .skip      (grp_skip[g]),
      .carry_out (carry[g+1])
    );

    // Skip path must agree with the cell ripple it bypasses
    AST_SKIP_MATCH: assert property (@(posedge clk) disable iff (rst)
      grp_skip[g] |-> (carry[g+1] == grp_ripple[g])); // R10
  end

  sweep_encoder #(.N(N_STATES)) enc_i (
    .onehot(time_c),
    .index (idx_c),
    .none  (none_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      valid      <= 1'b0;
      time_vec   <= '0;
      time_idx   <= '0;
      not_found  <= 1'b0;
      search_vec <= '0;
    end else begin
      valid <= start;
      if (start) begin
        time_vec   <= time_c;
        time_idx   <= idx_c;
        not_found  <= none_c;
        search_vec <= search_c;
      end
    end
  end

  AST_TIME_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    start && $onehot(begin_vec) |-> $onehot0(time_c)); // R3

  AST_SEARCH_STOPS: assert property (@(posedge clk) disable iff (rst)
    (time_c & search_c) == '0); // R7

  AST_VALID_NEXT: assert property (@(posedge clk) disable iff (rst)
    start |=> valid); // R2

  AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (rst)
    !start |=> !valid && $stable(time_vec) && $stable(search_vec)); // R2

  AST_NOTFOUND_ZERO: assert property (@(posedge clk) disable iff (rst)
    not_found |-> (time_vec == '0) && (time_idx == '0)); // R8

  AST_IDX_MATCH: assert property (@(posedge clk) disable iff (rst)
    valid && !not_found |-> time_vec[time_idx]); // R9
endmodule

// File: tb/sweep_flag_search_tb_top.sv
`timescale 1ns/1ps
module sweep_flag_search_tb_top;
  localparam int N = 16;

  logic          clk = 1'b0;
  logic          rst;
  logic          start;
  logic [N-1:0]  begin_vec;
  logic [N-1:0]  state_flags;
  logic          valid;
  logic [N-1:0]  time_vec;
  logic [3:0]    time_idx;
  logic          not_found;
  logic [N-1:0]  search_vec;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #4 clk = ~clk;

  sweep_flag_search dut_i (
    .clk(clk), .rst(rst), .start(start),
    .begin_vec(begin_vec), .state_flags(state_flags),
    .valid(valid), .time_vec(time_vec), .time_idx(time_idx),
    .not_found(not_found), .search_vec(search_vec)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int first_sel(input int b, input logic [N-1:0] st);
    for (int i = b; i < N; i++) if (st[i]) return i;
    return -1;
  endfunction

  function automatic logic [N-1:0] exp_search(input int b, input logic [N-1:0] st);
    logic [N-1:0] v = '0;
    for (int i = b; i < N; i++) begin
      if (st[i]) break;
      v[i] = 1'b1;
    end
    return v;
  endfunction

  task automatic run(input int b, input logic [N-1:0] st, input string req);
    int sel;
    logic [N-1:0] ev;
    sel = first_sel(b, st);
    ev  = (sel >= 0) ? (N'(1) << sel) : '0;
    begin_vec   = N'(1) << b;
    state_flags = st;
    start       = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk({req, " R2 valid"}, 32'(valid), 32'd1);
    chk({req, " R3 time_vec"}, 32'(time_vec), 32'(ev));
    chk({req, " R9 time_idx"}, 32'(time_idx), (sel >= 0) ? 32'(sel) : 32'd0);
    chk({req, " R8 not_found"}, 32'(not_found), (sel < 0) ? 32'd1 : 32'd0);
    chk({req, " R7 search_vec"}, 32'(search_vec), 32'(exp_search(b, st)));
    begin_vec   = ~begin_vec;
    state_flags = ~st;
    @(negedge clk);
    chk({req, " R2 hold valid"}, 32'(valid), 32'd0);
    chk({req, " R2 hold time"}, 32'(time_vec), 32'(ev));
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=<100000", cyc);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst = 1'b1; start = 1'b0; begin_vec = '0; state_flags = '0;
    repeat (3) @(negedge clk);
    chk("R1 valid in reset", 32'(valid), 32'd0);
    chk("R1 time_vec in reset", 32'(time_vec), 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 idle time_idx", 32'(time_idx), 32'd0);
    chk("R1 idle not_found", 32'(not_found), 32'd0);
    chk("R1 idle search_vec", 32'(search_vec), 32'd0);

    run(5,  16'h0020, "R4 begin slot chosen");
    run(0,  16'h0001, "R4 slot zero");
    run(8,  16'h00FF, "R5 low flags ignored");
    run(6,  16'h0000, "R8 empty row");
    run(15, 16'h7FFF, "R8 top slot empty");
    run(15, 16'h8000, "R9 top slot");
    run(3,  16'hFFFF, "R6 upper flags ignored");
    run(1,  16'h2000, "R10 skip two groups");
    run(0,  16'h8000, "R10 skip to last");
    run(4,  16'h1010, "R4 group edge");

    for (int k = 0; k < 300; k++) begin
      int b;
      logic [N-1:0] st;
      b  = int'($urandom_range(0, N-1));
      st = N'($urandom);
      case ($urandom_range(0, 3))
        0: st = st & N'($urandom);
        1: st = st & N'($urandom) & N'($urandom);
        2: st = '0;
        default: ;
      endcase
      run(b, st, "R3 random");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule